// File: doc/BRIEF.md
# Preloadable Rollover Tick Timer

This block is a 16-bit up-counting periodic timer for a peripheral controller. A separate prescaler delivers a one-cycle timing strobe at a fixed rate (nominally 160 kHz). While the timer runs, each strobe advances the counter by one. When the counter is at its all-ones value and another strobe arrives, it does not wrap to zero. It reloads from a programmable preload register. The same edge bumps a small overflow tally and marks an interrupt as pending. The period in strobes is therefore (2^16 - preload).

Software reaches the block through four registers on a simple single-cycle register bus: the preload value, a read-only count, a control register and an interrupt control register. The control register starts, stops and clears the timer, and it shows the overflow tally in its upper nibble. The tally changes on the same edge as the count. Software can therefore read tally, count and tally again, and build a continuous timebase from the count plus the number of periods elapsed. The interrupt request is the pending flag gated by an enable. It carries a programmable 3-bit level.

Top module: `rtt_top`

## Requirements
- R1: After reset the preload, count, control and interrupt control registers all read 0, `irq_req` is 0 and `irq_level` is 0.
- R2: When control bits 1:0 are both 1 (value 0x3), each cycle with `tick` high advances the count by one. The count holds in cycles without `tick`, and it also holds while control bits 1:0 are 0x1 or 0x2.
- R3: A `tick` that finds the running count at 0xFFFF loads the count from the preload value held before that edge. This event is a rollover.
- R4: A write to the preload register (address 0) leaves the count unchanged. The new value is used at the next rollover or clear.
- R5: A control write (address 2) with bit 1 equal to 0 stops the timer and loads the count from the preload register. A `tick` in that same cycle causes no rollover: the tally and the pending flag are untouched.
- R6: Control bits 7:4 read the overflow tally. It rises by one on each rollover and saturates at 15.
- R7: Writing 1 to control bit 2 sets the tally to 0. Bit 2 and bit 3 always read 0. If a rollover falls in the same cycle, the tally becomes 1.
- R8: The interrupt control register (address 3) holds the level in bits 2:0 and the enable in bit 3. Bit 7 reads the pending flag, which each rollover sets. Writing 1 to bit 7 clears it, but a rollover in the same cycle leaves it set.
- R9: `irq_req` is high exactly when the pending flag and the enable are both 1. `irq_level` equals the level field while `irq_req` is high and is 0 otherwise.
- R10: Address 1 reads the count, and writes to it are ignored. `bus_rdata` is 0 while `bus_sel` is low.
- R11: The count and the tally change on the same clock edge. A rollover is visible in both in the cycle right after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timing strobe from the prescaler |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 2 | Register address: 0 preload, 1 count, 2 control, 3 interrupt control |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 3 | Level of the request, 0 when not requesting |

## Verification
A rollover can fall in the same cycle as a software write that touches the same state. Three such writes are provoked: a clear-overflow command, an interrupt acknowledge, and a stop-and-clear write. In each case the bench drives `tick` together with the bus write while the count sits at 0xFFFF. It then expects a tally of 1 after the clear-overflow command, a pending flag that stays set after the acknowledge, and, after the stop write, a count at the preload with no tally step and no pending interrupt. Reads of count and tally in the same low clock phase after a rollover confirm that both moved on one edge.

// File: rtl/rtt_pkg.sv
package rtt_pkg;

   typedef enum logic [1:0] {
      RA_PRELOAD = 2'd0,
      RA_COUNT   = 2'd1,
      RA_CTRL    = 2'd2,
      RA_ICTL    = 2'd3
   } rtt_addr_e;

   // control register field positions
   localparam int CTL_RUN       = 0;
   localparam int CTL_ACT       = 1;
   localparam int CTL_OVCLR     = 2;
   localparam int CTL_TALLY_LSB = 4;

   // interrupt control field positions
   localparam int ICTL_EN  = 3;
   localparam int ICTL_ACK = 7;

endpackage

// File: rtl/rtt_count.sv
module rtt_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             load,
   input  logic [CNT_W-1:0] preload,
   output logic [CNT_W-1:0] count,
   output logic             roll
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic step;

   assign step = tick & run & ~load;
   assign roll = step & (count == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (load) begin
         count <= preload;
      end else if (roll) begin
         count <= preload;
      end else if (step) begin
         count <= count + 1'b1;
      end
   end

endmodule

// File: rtl/rtt_tally.sv
module rtt_tally #(
   parameter int TALLY_W  = 4,
   parameter bit SATURATE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               inc,
   input  logic               clr,
   output logic [TALLY_W-1:0] tally
);

   localparam logic [TALLY_W-1:0] T_ONE = TALLY_W'(1);
   localparam logic [TALLY_W-1:0] T_MAX = {TALLY_W{1'b1}};

   logic [TALLY_W-1:0] nxt_inc;

   generate
      if (SATURATE) begin : g_sat
         assign nxt_inc = (tally == T_MAX) ? T_MAX : tally + 1'b1;
      end else begin : g_wrap
         assign nxt_inc = tally + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tally <= '0;
      end else if (clr && inc) begin
         tally <= T_ONE;
      end else if (clr) begin
         tally <= '0;
      end else if (inc) begin
         tally <= nxt_inc;
      end
   end

endmodule

// File: rtl/rtt_irq.sv
module rtt_irq #(
   parameter int LVL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic             cfg_en,
   input  logic [LVL_W-1:0] cfg_lvl,
   input  logic             ack,
   input  logic             set,
   output logic             pend,
   output logic             en,
   output logic [LVL_W-1:0] lvl,
   output logic             irq_req,
   output logic [LVL_W-1:0] irq_level
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en  <= 1'b0;
         lvl <= '0;
      end else if (cfg_wr) begin
         en  <= cfg_en;
         lvl <= cfg_lvl;
      end
   end

   // a rollover in the acknowledge cycle keeps the flag set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
      end else if (set) begin
         pend <= 1'b1;
      end else if (ack) begin
         pend <= 1'b0;
      end
   end

   assign irq_req   = pend & en;
   assign irq_level = irq_req ? lvl : '0;

endmodule

// File: rtl/rtt_top.sv
module rtt_top #(
   parameter int CNT_W    = 16,
   parameter int DATA_W   = 16,
   parameter int TALLY_W  = 4,
   parameter int LVL_W    = 3,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_req,
   output logic [LVL_W-1:0]  irq_level
);

   import rtt_pkg::*;

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("rtt_top: CNT_W must be at least 2");
      end
      if (DATA_W < CNT_W || DATA_W < 8) begin : g_bad_data
         $error("rtt_top: DATA_W must cover CNT_W and at least 8 bits");
      end
      if (TALLY_W < 1 || TALLY_W > 4) begin : g_bad_tally
         $error("rtt_top: TALLY_W must be 1 to 4");
      end
      if (LVL_W < 1 || LVL_W > 3) begin : g_bad_lvl
         $error("rtt_top: LVL_W must be 1 to 3");
      end
   endgenerate

   logic               acc_wr;
   logic               wr_pre;
   logic               wr_ctl;
   logic               wr_ictl;
   logic [CNT_W-1:0]   pre_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [1:0]         ctl_q;
   logic [TALLY_W-1:0] tally_q;
   logic               pend_q;
   logic               ien_q;
   logic [LVL_W-1:0]   lvl_q;
   logic               run_w;
   logic               load_w;
   logic               ovf_clr_w;
   logic               roll_w;

   assign acc_wr  = bus_sel & bus_wr;
   assign wr_pre  = acc_wr & (rtt_addr_e'(bus_addr) == RA_PRELOAD);
   assign wr_ctl  = acc_wr & (rtt_addr_e'(bus_addr) == RA_CTRL);
   assign wr_ictl = acc_wr & (rtt_addr_e'(bus_addr) == RA_ICTL);

   assign run_w     = ctl_q[CTL_ACT] & ctl_q[CTL_RUN];
   assign load_w    = wr_ctl & ~bus_wdata[CTL_ACT];
   assign ovf_clr_w = wr_ctl & bus_wdata[CTL_OVCLR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (wr_pre) begin
         pre_q <= bus_wdata[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (wr_ctl) begin
         ctl_q <= bus_wdata[1:0];
      end
   end

   rtt_count #(.CNT_W(CNT_W)) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .run     (run_w),
      .load    (load_w),
      .preload (pre_q),
      .count   (cnt_q),
      .roll    (roll_w)
   );

   rtt_tally #(.TALLY_W(TALLY_W), .SATURATE(SATURATE)) u_tally (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (roll_w),
      .clr   (ovf_clr_w),
      .tally (tally_q)
   );

   rtt_irq #(.LVL_W(LVL_W)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (wr_ictl),
      .cfg_en    (bus_wdata[ICTL_EN]),
      .cfg_lvl   (bus_wdata[LVL_W-1:0]),
      .ack       (wr_ictl & bus_wdata[ICTL_ACK]),
      .set       (roll_w),
      .pend      (pend_q),
      .en        (ien_q),
      .lvl       (lvl_q),
      .irq_req   (irq_req),
      .irq_level (irq_level)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_sel) begin
         unique case (rtt_addr_e'(bus_addr))
            RA_PRELOAD: bus_rdata[CNT_W-1:0] = pre_q;
            RA_COUNT:   bus_rdata[CNT_W-1:0] = cnt_q;
            RA_CTRL: begin
               bus_rdata[1:0] = ctl_q;
               bus_rdata[CTL_TALLY_LSB +: TALLY_W] = tally_q;
            end
            RA_ICTL: begin
               bus_rdata[LVL_W-1:0] = lvl_q;
               bus_rdata[ICTL_EN]   = ien_q;
               bus_rdata[ICTL_ACK]  = pend_q;
            end
            default: bus_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/rtt_chk.sv
module rtt_chk #(
   parameter int CNT_W    = 16,
   parameter int TALLY_W  = 4,
   parameter int LVL_W    = 3,
   parameter bit SATURATE = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               tick,
   input logic               run,
   input logic               load,
   input logic               ovf_clr,
   input logic [CNT_W-1:0]   cnt,
   input logic [CNT_W-1:0]   pre,
   input logic [TALLY_W-1:0] tally,
   input logic               pend,
   input logic               ien,
   input logic [LVL_W-1:0]   lvl,
   input logic               irq_req,
   input logic [LVL_W-1:0]   irq_level
);

   logic at_max;
   logic roll_c;

   assign at_max = (cnt == {CNT_W{1'b1}});
   assign roll_c = tick && run && !load && at_max;

   // R2
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && run && !load && !at_max) |=> cnt == CNT_W'($past(cnt) + 1'b1));

   // R2
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(cnt));

   // R3
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      roll_c |=> cnt == $past(pre));

   // R5
   clear_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cnt == $past(pre));

   // R6
   tally_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (SATURATE && tally == {TALLY_W{1'b1}} && !ovf_clr) |=> tally == {TALLY_W{1'b1}});

   // R7
   tally_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_clr && !roll_c) |=> tally == '0);

   // R11
   tally_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (roll_c && !ovf_clr && tally != {TALLY_W{1'b1}}) |=> tally == TALLY_W'($past(tally) + 1'b1));

   // R8
   pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      roll_c |=> pend);

   // R9
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ien || !pend) |-> !irq_req);

   // R9
   irq_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> irq_level == lvl);

   // R9
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_req |-> irq_level == '0);

endmodule

bind rtt_top rtt_chk #(
   .CNT_W(CNT_W), .TALLY_W(TALLY_W), .LVL_W(LVL_W), .SATURATE(SATURATE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .run       (run_w),
   .load      (load_w),
   .ovf_clr   (ovf_clr_w),
   .cnt       (cnt_q),
   .pre       (pre_q),
   .tally     (tally_q),
   .pend      (pend_q),
   .ien       (ien_q),
   .lvl       (lvl_q),
   .irq_req   (irq_req),
   .irq_level (irq_level)
);

// File: tb/rtt_top_tb.sv
module rtt_top_tb;

   localparam logic [1:0] A_PRE  = 2'd0;
   localparam logic [1:0] A_CNT  = 2'd1;
   localparam logic [1:0] A_CTL  = 2'd2;
   localparam logic [1:0] A_ICTL = 2'd3;

   // {preload, tick count}
   localparam logic [31:0] VEC [6] = '{
      32'hFFF0_0005, 32'hFFF0_0010, 32'hFFFE_0028,
      32'h1234_0003, 32'hFFFF_0007, 32'hFFF8_0013
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq_req;
   logic [2:0]  irq_level;

   int n_run = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   rtt_top u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_req   (irq_req),
      .irq_level (irq_level)
   );

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic wr_tick(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick = 1'b1;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; tick = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] v);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 v = bus_rdata;
      bus_sel = 1'b0;
      #1;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick = 1'b1;
      end
      @(negedge clk);
      tick = 1'b0;
   endtask

   // count at 0xFFFF, preload 0xFFFD, tally 0, running
   task automatic arm_at_max();
      wr(A_PRE, 16'hFFFD);
      wr(A_CTL, 16'h0004);
      wr(A_CTL, 16'h0003);
      ticks(2);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] v;
      logic [15:0] v2;
      logic [15:0] m;
      logic [15:0] p;
      int          n;
      int          t;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_PRE, v);  chk("R1 preload", v, 16'h0);
      rd(A_CNT, v);  chk("R1 count", v, 16'h0);
      rd(A_CTL, v);  chk("R1 control", v, 16'h0);
      rd(A_ICTL, v); chk("R1 intctl", v, 16'h0);
      chk("R1 irq_req", {15'b0, irq_req}, 16'h0);
      chk("R1 irq_level", {13'b0, irq_level}, 16'h0);
      // R10 idle bus reads zero
      bus_addr = A_CTL; #1;
      chk("R10 rdata idle", bus_rdata, 16'h0);

      // vector table: R2 counting, R3 reload, R6 tally
      t = 0;
      for (int k = 0; k < 6; k++) begin
         p = VEC[k][31:16];
         n = int'(VEC[k][15:0]);
         wr(A_PRE, p);
         wr(A_CTL, 16'h0004);
         wr(A_CTL, 16'h0003);
         ticks(n);
         m = p; t = 0;
         for (int i = 0; i < n; i++) begin
            if (m == 16'hFFFF) begin
               m = p;
               if (t != 15) t++;
            end else begin
               m = m + 16'h1;
            end
         end
         rd(A_CNT, v); chk("R2/R3 vector count", v, m);
         rd(A_CTL, v); chk("R6 vector tally", v, 16'(t << 4) | 16'h0003);
      end

      // R10 write to count address ignored
      wr(A_CTL, 16'h0000);
      wr(A_CNT, 16'hABCD);
      rd(A_CNT, v); chk("R10 count write ignored", v, 16'hFFF8);

      // R2 hold while control is 0x2 or 0x1
      wr(A_CTL, 16'h0002);
      ticks(3);
      rd(A_CNT, v); chk("R2 hold ctl=2", v, 16'hFFF8);
      rd(A_CTL, v); chk("R2 ctl readback", v & 16'h000F, 16'h0002);
      wr(A_CTL, 16'h0001);
      ticks(3);
      rd(A_CNT, v); chk("R2 hold ctl=1", v, 16'hFFF8);

      // R4 preload write deferred to next reload
      wr(A_PRE, 16'hFFFC);
      wr(A_CTL, 16'h0004);
      wr(A_CTL, 16'h0003);
      ticks(2);
      wr(A_PRE, 16'h1000);
      rd(A_CNT, v); chk("R4 count unchanged", v, 16'hFFFE);
      ticks(2);
      // R11 both visible right after the rollover
      rd(A_CNT, v);
      rd(A_CTL, v2);
      chk("R4 new preload used", v, 16'h1000);
      chk("R11 tally with count", v2, 16'h0013);

      // R5 stop write in a rollover cycle
      arm_at_max();
      wr(A_ICTL, 16'h0088);
      wr_tick(A_CTL, 16'h0000);
      rd(A_CNT, v);  chk("R5 count loaded", v, 16'hFFFD);
      rd(A_CTL, v);  chk("R5 no tally step", v, 16'h0000);
      rd(A_ICTL, v); chk("R5 no pending", v, 16'h0008);

      // R7 clear-overflow, alone and with a rollover
      arm_at_max();
      ticks(1);
      rd(A_CTL, v); chk("R7 tally before clear", v, 16'h0013);
      wr(A_CTL, 16'h0007);
      rd(A_CTL, v); chk("R7 cleared, bit2 reads 0", v, 16'h0003);
      ticks(2);
      wr_tick(A_CTL, 16'h0007);
      rd(A_CTL, v); chk("R7 clear with rollover", v, 16'h0013);
      rd(A_CNT, v); chk("R7 count reloaded", v, 16'hFFFD);

      // R8 / R9 interrupt behaviour
      arm_at_max();
      wr(A_ICTL, 16'h008D);
      rd(A_ICTL, v); chk("R8 ack clears pending", v, 16'h000D);
      chk("R9 irq low", {15'b0, irq_req}, 16'h0);
      ticks(1);
      rd(A_ICTL, v); chk("R8 rollover sets pending", v, 16'h008D);
      chk("R9 irq high", {15'b0, irq_req}, 16'h1);
      chk("R9 irq level", {13'b0, irq_level}, 16'h5);
      wr(A_ICTL, 16'h008D);
      chk("R9 irq after ack", {15'b0, irq_req}, 16'h0);
      ticks(2);
      wr_tick(A_ICTL, 16'h008D);
      rd(A_ICTL, v); chk("R8 ack with rollover keeps pending", v, 16'h008D);
      wr(A_ICTL, 16'h0005);
      rd(A_ICTL, v); chk("R8 pending while disabled", v, 16'h0085);
      chk("R9 disabled irq", {15'b0, irq_req}, 16'h0);
      chk("R9 disabled level", {13'b0, irq_level}, 16'h0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule